// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

The controller turns single read and write requests from inside the chip into timed cycles on an external static memory bus. Four banks share one address bus, one data bus and the read and write strobes. Each bank has its own active-low chip select. Each bank can hold an SRAM, ROM, NOR flash or PSRAM device with an 8-, 16- or 32-bit data path. The bank can use separate address and data lines, or put the low address bits on the data lines behind an address-valid strobe.

Each access runs through the same phases: an address phase, a data phase and a turnaround gap. Reads and writes each have their own 16-bit timing word. That word sets the address-phase length, the delay before the strobe, the wait states and the turnaround. A request is held high until the controller answers with a one-cycle done pulse. A divided memory clock is also produced. It runs either all the time or only while an access is on the bus.

Top module: `smc_async_ctrl`

## Requirements
- R1: While an access is in its address or data phase, only the chip select of the requested bank (bit index equal to the bank number) is low. At all other times every chip select is high.
- R2: Each timing word is split into four fields. Bits [3:0] are setup S, bits [7:4] are strobe delay D, bits [11:8] are wait states W and bits [15:12] are turnaround T. The address phase lasts S+1 cycles. The data phase lasts D+W+1 cycles. The strobe is low for the last W+1 cycles of the data phase.
- R3: A read uses only the read timing word and a write uses only the write timing word. The other word has no effect on the access.
- R4: After a data phase, all chip selects stay high for T cycles of turnaround. A request held during turnaround is not started until the turnaround ends. Between back-to-back accesses, the chip selects are high for exactly T+1 cycles.
- R5: The done pulse is high for exactly one cycle, in the cycle after the last data-phase cycle. For a read, the read data output then holds the bus value sampled in that last data cycle, while the strobe is still low.
- R6: Each bank has a 2-bit width code in bits [2b+1:2b]. Code 0 means 8 bits, code 1 means 16 bits, and codes 2 and 3 mean 32 bits. The external address is the byte address shifted right by 0, 1 or 2 bits. It is driven during both phases and is zero outside them. Read data above the device width reads as zero.
- R7: A bank whose multiplex bit is set pulls address-valid low for the whole address phase. During that phase it drives the external address on the data lanes of the device width. On a read the data bus is never driven while output-enable is low. A bank whose multiplex bit is clear never pulls address-valid low and never drives the bus on a read.
- R8: A write drives the write data on the lanes of the device width (lane enable bits 0, 0–1 or 0–3) and pulses write-enable. Output-enable stays high. A read pulses only output-enable.
- R9: The memory clock toggles after every K+1 enabled cycles, where K is the divider input. In continuous mode it is always enabled. In gated mode it is enabled only during address and data phases, and it is held low otherwise.
- R10: While reset is applied and right after it, every chip select, output-enable, write-enable and address-valid output is high. Done is low, no data lane is driven and the memory clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until done |
| req_we | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_addr | input | 26 | Byte address |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with done |
| cfg_width | input | 8 | Width code per bank |
| cfg_mux | input | 4 | Multiplexed-bus enable per bank |
| cfg_rd_tim | input | 16 | Read timing word |
| cfg_wr_tim | input | 16 | Write timing word |
| cfg_clk_div | input | 4 | Memory clock divider K |
| cfg_clk_cont | input | 1 | 1 = memory clock always runs |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_addr | output | 26 | External address |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 32 | Data bus driver value |
| mem_dq_oe | output | 4 | Data bus drive enable per byte lane |
| mem_dq_in | input | 32 | Data bus receiver value |
| mem_clk | output | 1 | Divided memory clock |

## Verification
Two events can land in the same cycle. One is the done pulse that closes an access. The other is the start of the next request, which happens when the turnaround is zero. In that case, completion and acceptance of the next request share one idle cycle. The bench provokes this by keeping the request high at the done pulse and switching it to another bank in the same cycle. It does this with turnaround 0 and with turnaround 3. It then judges the outcome by counting the cycles in which every chip select is high. This count must be T+1, and afterwards the new bank's select must be the only one low.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam int TF_W  = 4;
  localparam int TIM_W = 4 * TF_W;

  typedef struct packed {
    logic [TF_W-1:0] turn;
    logic [TF_W-1:0] wait_st;
    logic [TF_W-1:0] strb_dly;
    logic [TF_W-1:0] setup;
  } smc_tim_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_TURN = 2'd3
  } smc_phase_e;

  // Right shift from byte address to device word address.
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // Data phase counter start: strobe delay plus wait states.
  function automatic logic [TF_W:0] data_span(input smc_tim_t t);
    return {1'b0, t.strb_dly} + {1'b0, t.wait_st};
  endfunction

  // Byte lanes active for a width code.
  function automatic int lane_count(input logic [1:0] code);
    return 1 << width_shift(code);
  endfunction

endpackage

// File: rtl/smc_clkdiv.sv
module smc_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mclk
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mclk  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mclk  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mclk  <= ~mclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r9_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mclk);

  a_r9_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(mclk));

endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [TIM_W-1:0] rd_tim,
  input  logic [TIM_W-1:0] wr_tim,
  output smc_phase_e       phase,
  output logic             start_evt,
  output logic             last_data,
  output logic             strobe_on,
  output logic             done
);

  smc_tim_t        tim_q;
  smc_tim_t        tim_sel;
  logic [TF_W:0]   cnt_q;

  assign tim_sel   = req_we ? smc_tim_t'(wr_tim) : smc_tim_t'(rd_tim);
  assign start_evt = (phase == PH_IDLE) && req;
  assign last_data = (phase == PH_DATA) && (cnt_q == '0);
  assign strobe_on = (phase == PH_DATA) && (cnt_q <= {1'b0, tim_q.wait_st});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      tim_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_data;
      unique case (phase)
        PH_IDLE: if (req) begin
          tim_q <= tim_sel;
          cnt_q <= {1'b0, tim_sel.setup};
          phase <= PH_ADDR;
        end
        PH_ADDR: if (cnt_q == '0) begin
          cnt_q <= data_span(tim_q);
          phase <= PH_DATA;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_DATA: if (cnt_q == '0) begin
          cnt_q <= {1'b0, tim_q.turn} - 1'b1;
          phase <= (tim_q.turn == '0) ? PH_IDLE : PH_TURN;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_TURN: if (cnt_q == '0) begin
          phase <= PH_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r4_turn_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |=> (phase != PH_ADDR));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == PH_DATA));

  a_r2_strobe_held_to_end: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !last_data) |=> strobe_on);

endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import smc_pkg::*;
#(
  parameter  int NBANK  = 4,
  parameter  int ADDR_W = 26,
  parameter  int DATA_W = 32,
  localparam int BANK_W = $clog2(NBANK),
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smc_phase_e        phase,
  input  logic              start_evt,
  input  logic              last_data,
  input  logic              strobe_on,
  input  logic              req_we,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [2*NBANK-1:0] cfg_width,
  input  logic [NBANK-1:0]  cfg_mux,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic [NBANK-1:0]  mem_cs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [LANES-1:0]  mem_dq_oe
);

  logic              we_q;
  logic              mux_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] eaddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        code_q;
  logic [1:0]        code_req;
  logic [LANES-1:0]  lanes;
  logic [DATA_W-1:0] bits;
  logic [DATA_W-1:0] addr_on_dq;
  logic              in_acc;
  logic              addr_drive;
  logic              data_drive;

  assign code_req = cfg_width[2*req_bank +: 2];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lanes[l]        = (l < lane_count(code_q));
      bits[8*l +: 8]  = {8{lanes[l]}};
    end
  end

  generate
    if (ADDR_W >= DATA_W) begin : g_addr_trunc
      assign addr_on_dq = eaddr_q[DATA_W-1:0];
    end else begin : g_addr_ext
      assign addr_on_dq = {{(DATA_W-ADDR_W){1'b0}}, eaddr_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      mux_q   <= 1'b0;
      bank_q  <= '0;
      eaddr_q <= '0;
      wdata_q <= '0;
      code_q  <= '0;
      rdata   <= '0;
    end else begin
      if (start_evt) begin
        we_q    <= req_we;
        mux_q   <= cfg_mux[req_bank];
        bank_q  <= req_bank;
        eaddr_q <= req_addr >> width_shift(code_req);
        wdata_q <= req_wdata;
        code_q  <= code_req;
      end
      if (last_data && !we_q) begin
        rdata <= mem_dq_in & bits;
      end
    end
  end

  assign in_acc     = (phase == PH_ADDR) || (phase == PH_DATA);
  assign addr_drive = (phase == PH_ADDR) && mux_q;
  assign data_drive = (phase == PH_DATA) && we_q;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_cs
      assign mem_cs_n[b] = !(in_acc && (bank_q == BANK_W'(b)));
    end
  endgenerate

  assign mem_addr   = in_acc ? eaddr_q : '0;
  assign mem_adv_n  = !addr_drive;
  assign mem_oe_n   = !(strobe_on && !we_q);
  assign mem_we_n   = !(strobe_on && we_q);
  assign mem_dq_oe  = (addr_drive || data_drive) ? lanes : '0;
  assign mem_dq_out = addr_drive ? (addr_on_dq & bits) :
                      data_drive ? (wdata_q & bits) : '0;

  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r7_bus_free_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_dq_oe == '0));

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r7_adv_clear_of_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_oe_n && mem_we_n));

  a_r1_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

endmodule

// File: rtl/smc_async_ctrl.sv
module smc_async_ctrl
  import smc_pkg::*;
#(
  parameter  int NBANK  = 4,
  parameter  int ADDR_W = 26,
  parameter  int DATA_W = 32,
  parameter  int DIV_W  = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int LANES  = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_we,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  input  logic [2*NBANK-1:0] cfg_width,
  input  logic [NBANK-1:0]   cfg_mux,
  input  logic [TIM_W-1:0]   cfg_rd_tim,
  input  logic [TIM_W-1:0]   cfg_wr_tim,
  input  logic [DIV_W-1:0]   cfg_clk_div,
  input  logic               cfg_clk_cont,
  output logic [NBANK-1:0]   mem_cs_n,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_adv_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic [LANES-1:0]   mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in,
  output logic               mem_clk
);

  smc_phase_e phase;
  logic       start_evt;
  logic       last_data;
  logic       strobe_on;
  logic       clk_run;

  smc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_we    (req_we),
    .rd_tim    (cfg_rd_tim),
    .wr_tim    (cfg_wr_tim),
    .phase     (phase),
    .start_evt (start_evt),
    .last_data (last_data),
    .strobe_on (strobe_on),
    .done      (done)
  );

  smc_datapath #(
    .NBANK  (NBANK),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .start_evt  (start_evt),
    .last_data  (last_data),
    .strobe_on  (strobe_on),
    .req_we     (req_we),
    .req_bank   (req_bank),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cfg_width  (cfg_width),
    .cfg_mux    (cfg_mux),
    .mem_dq_in  (mem_dq_in),
    .rdata      (rdata),
    .mem_cs_n   (mem_cs_n),
    .mem_addr   (mem_addr),
    .mem_adv_n  (mem_adv_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  assign clk_run = cfg_clk_cont || (phase == PH_ADDR) || (phase == PH_DATA);

  smc_clkdiv #(.DIV_W(DIV_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (clk_run),
    .div   (cfg_clk_div),
    .mclk  (mem_clk)
  );

  a_r4_cs_high_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&mem_cs_n));

endmodule

// File: tb/sim_smc_async_ctrl.sv
module sim_smc_async_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic [7:0]  cfg_width = '0;
  logic [3:0]  cfg_mux = '0;
  logic [15:0] cfg_rd_tim = '0, cfg_wr_tim = '0;
  logic [3:0]  cfg_clk_div = '0;
  logic        cfg_clk_cont = 1'b0;
  logic [3:0]  cs_n;
  logic [25:0] maddr;
  logic        adv_n, oe_n, we_n, mclk;
  logic [31:0] dq_out, dq_in = '0;
  logic [3:0]  dq_oe;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  smc_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_bank(req_bank),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .cfg_width(cfg_width), .cfg_mux(cfg_mux), .cfg_rd_tim(cfg_rd_tim),
    .cfg_wr_tim(cfg_wr_tim), .cfg_clk_div(cfg_clk_div), .cfg_clk_cont(cfg_clk_cont),
    .mem_cs_n(cs_n), .mem_addr(maddr), .mem_adv_n(adv_n), .mem_oe_n(oe_n),
    .mem_we_n(we_n), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in),
    .mem_clk(mclk)
  );

  // {we, bank, width code, mux, timing, byte address, write data, bus data}
  localparam logic [111:0] VT [8] = '{
    {1'b0, 2'd0, 2'd2, 1'b0, 16'h1210, 26'h0000104, 32'h0,         32'hCAFE_F00D},
    {1'b1, 2'd1, 2'd1, 1'b0, 16'h0302, 26'h0000ABC, 32'h1357_9BDF, 32'h0},
    {1'b0, 2'd2, 2'd0, 1'b1, 16'h2013, 26'h00012F5, 32'h0,         32'h8899_AABB},
    {1'b1, 2'd3, 2'd2, 1'b1, 16'h0F00, 26'h3FFFFFC, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 2'd1, 2'd1, 1'b1, 16'h0000, 26'h0000002, 32'h0,         32'h5566_7788},
    {1'b1, 2'd0, 2'd0, 1'b0, 16'h00F0, 26'h0000033, 32'hFFFF_FF5A, 32'h0},
    {1'b0, 2'd3, 2'd3, 1'b0, 16'h000F, 26'h1234567, 32'h0,         32'h0F0F_F0F0},
    {1'b1, 2'd2, 2'd1, 1'b1, 16'h5555, 26'h2AAAAAA, 32'h0000_C3C3, 32'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bus_mask(input logic [1:0] wc);
    case (wc)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] oe_mask(input logic [1:0] wc);
    case (wc)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int shift_of(input logic [1:0] wc);
    return (wc == 2'd0) ? 0 : (wc == 2'd1) ? 1 : 2;
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  // Back-to-back reads: bank 0 then bank 1 with turnaround t.
  task automatic back_to_back(input logic [3:0] t);
    int gap;
    @(negedge clk);
    cfg_rd_tim = {t, 12'h000}; cfg_wr_tim = 16'hFFFF;
    cfg_width = 8'hAA; cfg_mux = 4'h0;
    req_we = 0; req_bank = 2'd0; req_addr = 26'h40; req = 1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (done) break;
    end
    req_bank = 2'd1; req_addr = 26'h80;
    gap = (cs_n == 4'hF) ? 1 : 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (cs_n != 4'hF) break;
      gap++;
    end
    chk(gap == int'(t) + 1, "R4 chip-select gap between accesses", gap, int'(t) + 1);
    chk(cs_n == 4'b1101, "R4 next bank selected after gap", cs_n, 4'b1101);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (done) break;
    end
    req = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    logic [111:0] v;
    logic we, mux;
    logic [1:0] bank, wc;
    logic [15:0] tim;
    logic [25:0] addr, eaddr;
    logic [31:0] wd, din, bits;
    logic [3:0] lanes;
    int as, sd, wt, exp_cs, exp_first, exp_done;
    int cs_cnt, s_len, s_first, adv_cnt, done_at, prev_c, changes;
    bit bad_cs, bad_addr, bad_str, bad_mux, bad_wr, bad_rdbus, idle_clk_bad;
    logic prev_clk;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n == 4'hF, "R10 chip selects high in reset", cs_n, 4'hF);
    chk({oe_n, we_n, adv_n} == 3'b111, "R10 strobes high in reset", {oe_n, we_n, adv_n}, 3'b111);
    chk(done == 0 && dq_oe == 0 && mclk == 0, "R10 done, lanes, clock idle in reset",
        {done, dq_oe, mclk}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 4'hF && dq_oe == 0, "R10 idle after reset", {cs_n, dq_oe}, 8'hF0);

    for (int i = 0; i < 8; i++) begin
      v = VT[i];
      we = v[111]; bank = v[110:109]; wc = v[108:107]; mux = v[106];
      tim = v[105:90]; addr = v[89:64]; wd = v[63:32]; din = v[31:0];
      as = int'(tim[3:0]); sd = int'(tim[7:4]); wt = int'(tim[11:8]);
      exp_cs = as + 1 + sd + wt + 1; exp_first = as + 1 + sd + 1; exp_done = exp_cs + 1;
      eaddr = addr >> shift_of(wc); bits = bus_mask(wc); lanes = oe_mask(wc);
      cs_cnt = 0; s_len = 0; s_first = 0; adv_cnt = 0; done_at = 0;
      bad_cs = 0; bad_addr = 0; bad_str = 0; bad_mux = 0; bad_wr = 0; bad_rdbus = 0;
      @(negedge clk);
      cfg_width[2*bank +: 2] = wc; cfg_mux[bank] = mux;
      // R3: the unused set is all-ones, which would stretch every phase
      if (we) begin cfg_wr_tim = tim; cfg_rd_tim = 16'hFFFF; end
      else    begin cfg_rd_tim = tim; cfg_wr_tim = 16'hFFFF; end
      req_we = we; req_bank = bank; req_addr = addr; req_wdata = wd; dq_in = din; req = 1;
      for (int c = 1; c <= 80; c++) begin
        @(negedge clk);
        if (cs_n != 4'hF) begin
          cs_cnt++;
          if (cs_n != ~(4'b0001 << bank)) bad_cs = 1;
          if (maddr != eaddr) bad_addr = 1;
        end else if (maddr != 0) bad_addr = 1;
        if (we ? !we_n : !oe_n) begin
          if (s_len == 0) s_first = c;
          s_len++;
          if (we && (dq_oe != lanes || (dq_out & bits) != (wd & bits))) bad_wr = 1;
        end
        if (we ? !oe_n : !we_n) bad_str = 1;
        if (!adv_n) begin
          adv_cnt++;
          if (dq_oe != lanes || (dq_out & bits) != ({6'b0, eaddr} & bits)) bad_mux = 1;
        end
        if (!we && adv_n && dq_oe != 0) bad_rdbus = 1;
        if (done) begin done_at = c; break; end
      end
      req = 0;
      chk(cs_cnt == exp_cs, $sformatf("R2 R3 vec%0d chip-select length", i), cs_cnt, exp_cs);
      chk(!bad_cs, $sformatf("R1 vec%0d only target bank selected", i), bad_cs, 0);
      chk(s_len == wt + 1, $sformatf("R2 vec%0d strobe length", i), s_len, wt + 1);
      chk(s_first == exp_first, $sformatf("R2 vec%0d strobe start cycle", i), s_first, exp_first);
      chk(!bad_str, $sformatf("R8 vec%0d opposite strobe stays high", i), bad_str, 0);
      chk(!bad_addr, $sformatf("R6 vec%0d external address", i), bad_addr, 0);
      chk(adv_cnt == (mux ? as + 1 : 0), $sformatf("R7 vec%0d address-valid length", i),
          adv_cnt, mux ? as + 1 : 0);
      chk(!bad_mux, $sformatf("R7 vec%0d address on data lanes", i), bad_mux, 0);
      chk(done_at == exp_done, $sformatf("R5 vec%0d done cycle", i), done_at, exp_done);
      if (we) chk(!bad_wr, $sformatf("R8 R6 vec%0d write lanes and data", i), bad_wr, 0);
      else begin
        chk(!bad_rdbus, $sformatf("R7 vec%0d bus released on read", i), bad_rdbus, 0);
        chk(rdata == (din & bits), $sformatf("R5 R6 vec%0d read data", i), rdata, din & bits);
      end
      @(negedge clk);
      chk(done == 0, $sformatf("R5 vec%0d done one cycle", i), done, 0);
      repeat (20) @(negedge clk);
    end

    // R4: request overlapping completion and turnaround
    back_to_back(4'd0);
    back_to_back(4'd3);

    // R9 continuous clock, divider 2 -> change every 3 cycles
    cfg_clk_cont = 1; cfg_clk_div = 4'd2;
    @(negedge clk);
    prev_clk = mclk;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (mclk != prev_clk) break;
    end
    for (int k = 0; k < 2; k++) begin
      prev_clk = mclk; prev_c = 0;
      for (int c = 1; c < 20; c++) begin
        @(negedge clk);
        if (mclk != prev_clk) begin prev_c = c; break; end
      end
      chk(prev_c == 3, "R9 continuous clock half period", prev_c, 3);
    end

    // R9 gated clock: low while idle, running during an access
    cfg_clk_cont = 0; cfg_clk_div = 4'd1;
    repeat (3) @(negedge clk);
    idle_clk_bad = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (mclk) idle_clk_bad = 1;
    end
    chk(!idle_clk_bad, "R9 gated clock low when idle", idle_clk_bad, 0);
    cfg_rd_tim = 16'h000F; req_we = 0; req_bank = 2'd0; req = 1;
    changes = 0; prev_clk = mclk;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (mclk != prev_clk) changes++;
      prev_clk = mclk;
      if (done) break;
    end
    req = 0;
    chk(changes >= 4, "R9 gated clock runs during access", changes, 4);
    repeat (5) @(negedge clk);
    chk(mclk == 0, "R9 gated clock low after access", mclk, 0);

    summary();
  end

endmodule